// File: doc/BRIEF.md
# Narrow Inter-Device Payload Serializer

This block moves a wide payload between two devices over a narrow link of 25 bits per direction. The payload is 256 bits: a 128-bit cipher state followed by a 128-bit key. The sending half cuts the payload into 23-bit slices. Each slice travels as one beat, together with two in-band control bits. The link adds a fixed pipeline delay of two clock cycles between the ends. The receiving half writes each slice into place using a beat counter. It releases the whole word only after the final beat has been captured.

Both halves run on one clock. The sender takes a new payload only while it is idle. It then sends the beats one per cycle with no gaps, starting with the lowest slice. The receiver gives a one-cycle completion pulse, and its output word stays unchanged until the next completion.

Top module: `slice_link`

## Requirements
- R1: While reset is asserted, `txIdle` is 1, `linkBeat` is 0, `rxDone` is 0 and `rxWord` is 0.
- R2: A load request seen while the sender is busy is ignored. The beats of the payload in flight, and the word reassembled from them, are unchanged.
- R3: Beat layout: bits [22:0] carry a data slice, bit 23 is the valid flag and bit 24 is the last flag. Beat k (counting from 0) carries payload bits [23k+22:23k].
- R4: A payload is sent as exactly 12 beats in 12 consecutive cycles. The first beat appears in the cycle after the load is accepted. The last flag is set on beat 11 only.
- R5: `txIdle` is 0 from the cycle after an accepted load until the last beat has been sent. It is 1 again in the cycle that follows the last beat.
- R6: Whenever no payload is being sent, `linkBeat` is all zero.
- R7: `rxDone` is a single-cycle pulse. It rises three cycles after the cycle in which the last beat appears on `linkBeat`: two cycles for the link and one for capture.
- R8: When `rxDone` is 1, `rxWord` equals the payload that was loaded. `rxWord` holds its value until the next `rxDone`.
- R9: After each completion the receiver's slot count returns to zero, so payloads sent back to back are each reassembled correctly.
- R10: Bits [22:3] of the last beat, which lie beyond payload bit 255, are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ends |
| rstN | input | 1 | Asynchronous reset, active low |
| loadValid | input | 1 | Request to send `loadWord`; accepted only while idle |
| loadWord | input | 256 | Payload to send |
| txIdle | output | 1 | Sender is free to accept a payload |
| linkBeat | output | 25 | Beat currently driven onto the link |
| rxDone | output | 1 | One-cycle pulse: the whole payload has arrived |
| rxWord | output | 256 | Reassembled payload, held between completions |

## Verification
The bench builds the block with its default parameters: a 256-bit payload, 23-bit slices and a two-stage hop. With these values the payload needs twelve beats, and the last beat carries only three real bits. The padding rule and the placement of a short final slice are therefore both exercised. With a two-stage hop the next payload is already leaving the sender while the tail of the previous one is still in the link. Holding the load request high across completions brings into reach the case where the receiver's count resets and a new payload begins right after it.

// File: rtl/slice_link_pkg.sv
package slice_link_pkg;
  // Offsets of the control bits above the data slice inside a beat
  localparam int CTRL_VALID = 0;
  localparam int CTRL_LAST  = 1;
  localparam int CTRL_W     = 2;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic txLoad;    // capture a new payload into the send register
    logic txStep;    // advance to the next slice
    logic txOn;      // a beat is being driven this cycle
    logic txLast;    // the beat being driven is the final one
    logic rxTake;    // write the arriving slice at the current slot
    logic rxFinish;  // arriving beat completes the payload
  } linkStrobe_t;
endpackage

// File: rtl/slice_link_ctrl.sv
module slice_link_ctrl
  import slice_link_pkg::*;
#(
  parameter int BEATS = 12,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadValid,
  input  logic             rxValid,
  input  logic             rxLast,
  output linkStrobe_t      strobe,
  output logic [CNT_W-1:0] rxSlot,
  output logic             txIdle
);
  localparam logic [CNT_W-1:0] FINAL_IDX = CNT_W'(BEATS - 1);

  logic             txActive;
  logic [CNT_W-1:0] txCnt;
  logic [CNT_W-1:0] rxCnt;
  logic             txAtEnd;

  assign txAtEnd = txActive && (txCnt == FINAL_IDX);

  always_comb begin
    strobe          = '0;
    strobe.txLoad   = !txActive && loadValid;
    strobe.txStep   = txActive && !txAtEnd;
    strobe.txOn     = txActive;
    strobe.txLast   = txAtEnd;
    strobe.rxTake   = rxValid;
    strobe.rxFinish = rxValid && rxLast;
  end

  assign rxSlot = rxCnt;
  assign txIdle = !txActive;

  // Sender sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActive <= 1'b0;
      txCnt    <= '0;
    end else if (!txActive) begin
      if (loadValid) begin
        txActive <= 1'b1;
        txCnt    <= '0;
      end
    end else if (txAtEnd) begin
      txActive <= 1'b0;
      txCnt    <= '0;
    end else begin
      txCnt <= txCnt + 1'b1;
    end
  end

  // Receiver slot counting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCnt <= '0;
    end else if (rxValid && rxLast) begin
      rxCnt <= '0;
    end else if (rxValid) begin
      rxCnt <= rxCnt + 1'b1;
    end
  end

  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> $past(loadValid)); // R2
  AST_TX_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    txActive |-> (txCnt <= FINAL_IDX)); // R4
  AST_TX_NO_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (txActive && txCnt != FINAL_IDX) |=> (txActive && txCnt == $past(txCnt) + 1'b1)); // R4
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    txAtEnd |=> txIdle); // R5
  AST_RX_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (rxCnt <= FINAL_IDX)); // R9
  AST_RX_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxLast) |=> (rxCnt == '0)); // R9
endmodule

// File: rtl/slice_link_path.sv
module slice_link_path
  import slice_link_pkg::*;
#(
  parameter int PAYLOAD_W = 256,
  parameter int SLICE_W   = 23,
  parameter int HOP       = 2,
  parameter int BEATS     = 12,
  parameter int CNT_W     = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  linkStrobe_t               strobe,
  input  logic [CNT_W-1:0]          rxSlot,
  input  logic [PAYLOAD_W-1:0]      loadWord,
  output logic [SLICE_W+CTRL_W-1:0] linkBeat,
  output logic                      rxValid,
  output logic                      rxLast,
  output logic                      rxDone,
  output logic [PAYLOAD_W-1:0]      rxWord
);
  localparam int PAD_W  = BEATS * SLICE_W;
  localparam int BEAT_W = SLICE_W + CTRL_W;
  localparam int LAST_W = PAYLOAD_W - (BEATS - 1) * SLICE_W;

  // ---------------- send side ----------------
  logic [PAD_W-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobe.txLoad) begin
      txShift <= PAD_W'(loadWord);
    end else if (strobe.txStep) begin
      txShift <= txShift >> SLICE_W;
    end
  end

  always_comb begin
    linkBeat = '0;
    if (strobe.txOn) begin
      linkBeat[SLICE_W-1:0]         = txShift[SLICE_W-1:0];
      linkBeat[SLICE_W + CTRL_VALID] = 1'b1;
      linkBeat[SLICE_W + CTRL_LAST]  = strobe.txLast;
    end
  end

  // ---------------- fixed-latency hop ----------------
  logic [BEAT_W-1:0] hopPipe [HOP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HOP; i++) hopPipe[i] <= '0;
    end else begin
      for (int i = HOP - 1; i > 0; i--) hopPipe[i] <= hopPipe[i-1];
      hopPipe[0] <= linkBeat;
    end
  end

  logic [BEAT_W-1:0] rxBeat;
  assign rxBeat  = hopPipe[HOP-1];
  assign rxValid = rxBeat[SLICE_W + CTRL_VALID];
  assign rxLast  = rxBeat[SLICE_W + CTRL_LAST];

  // ---------------- receive side ----------------
  logic [PAYLOAD_W-1:0] assembly;
  logic [PAYLOAD_W-1:0] nextAsm;

  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    localparam int LO = g * SLICE_W;
    localparam int W  = (PAYLOAD_W - LO < SLICE_W) ? (PAYLOAD_W - LO) : SLICE_W;
    assign nextAsm[LO +: W] = (strobe.rxTake && rxSlot == CNT_W'(g)) ?
                              rxBeat[W-1:0] : assembly[LO +: W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      assembly <= '0;
      rxWord   <= '0;
      rxDone   <= 1'b0;
    end else begin
      assembly <= nextAsm;
      rxDone   <= strobe.rxFinish;
      if (strobe.rxFinish) rxWord <= nextAsm;
    end
  end

  if (LAST_W < SLICE_W) begin : g_pad_chk
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      strobe.txLast |-> (linkBeat[SLICE_W-1:LAST_W] == '0)); // R10
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone); // R7
  AST_DONE_FROM_LAST: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> $past(rxValid && rxLast)); // R7
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rxDone |-> $stable(rxWord)); // R8
  AST_BEAT_IS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txOn |-> linkBeat[SLICE_W + CTRL_VALID]); // R3
endmodule

// File: rtl/slice_link.sv
module slice_link
  import slice_link_pkg::*;
#(
  parameter int PAYLOAD_W = 256,
  parameter int SLICE_W   = 23,
  parameter int HOP       = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadValid,
  input  logic [PAYLOAD_W-1:0] loadWord,
  output logic                 txIdle,
  output logic [SLICE_W+1:0]   linkBeat,
  output logic                 rxDone,
  output logic [PAYLOAD_W-1:0] rxWord
);
  localparam int BEATS = (PAYLOAD_W + SLICE_W - 1) / SLICE_W;
  localparam int CNT_W = $clog2(BEATS + 1);

  linkStrobe_t      strobe;
  logic [CNT_W-1:0] rxSlot;
  logic             rxValid;
  logic             rxLast;

  slice_link_ctrl #(
    .BEATS (BEATS),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadValid (loadValid),
    .rxValid   (rxValid),
    .rxLast    (rxLast),
    .strobe    (strobe),
    .rxSlot    (rxSlot),
    .txIdle    (txIdle)
  );

  slice_link_path #(
    .PAYLOAD_W (PAYLOAD_W),
    .SLICE_W   (SLICE_W),
    .HOP       (HOP),
    .BEATS     (BEATS),
    .CNT_W     (CNT_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rxSlot   (rxSlot),
    .loadWord (loadWord),
    .linkBeat (linkBeat),
    .rxValid  (rxValid),
    .rxLast   (rxLast),
    .rxDone   (rxDone),
    .rxWord   (rxWord)
  );
endmodule

// File: tb/sim_slice_link.sv
`timescale 1ns/1ps
module sim_slice_link;
  localparam int PW  = 256;
  localparam int SW  = 23;
  localparam int HOP = 2;
  localparam int NB  = (PW + SW - 1) / SW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadValid = 1'b0;
  logic [PW-1:0] loadWord = '0;
  logic          txIdle;
  logic [SW+1:0] linkBeat;
  logic          rxDone;
  logic [PW-1:0] rxWord;

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  bit running = 0;

  always #2.5 clk = ~clk;

  slice_link u0 (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadWord(loadWord),
    .txIdle(txIdle), .linkBeat(linkBeat), .rxDone(rxDone), .rxWord(rxWord)
  );

  task automatic chk(string req, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [PW-1:0] mPay = '0;
  int            mIdx = 0;
  bit            mBusy = 0;
  logic [SW+1:0] mPipe [HOP];
  logic [SW+1:0] rin;
  logic [PW-1:0] mAsm = '0;
  logic [PW-1:0] mWord = '0;
  int            mCnt = 0;
  bit            mDone = 0;
  int            mDoneCount = 0;

  function automatic logic [SW+1:0] mkBeat(bit busy, int idx, logic [PW-1:0] pay);
    logic [SW+1:0] b;
    b = '0;
    if (busy) begin
      for (int k = 0; k < SW; k++) begin
        if (idx * SW + k < PW) b[k] = pay[idx * SW + k];
      end
      b[SW]     = 1'b1;
      b[SW + 1] = (idx == NB - 1);
    end
    return b;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mBusy = 0; mIdx = 0; mPay = '0; mAsm = '0; mWord = '0; mCnt = 0; mDone = 0;
      for (int i = 0; i < HOP; i++) mPipe[i] = '0;
    end else begin
      rin   = mPipe[HOP-1];
      mDone = 0;
      if (rin[SW]) begin
        for (int k = 0; k < SW; k++) begin
          if (mCnt * SW + k < PW) mAsm[mCnt * SW + k] = rin[k];
        end
        if (rin[SW + 1]) begin
          mWord = mAsm; mDone = 1; mCnt = 0; mDoneCount++;
        end else begin
          mCnt++;
        end
      end
      for (int i = HOP - 1; i > 0; i--) mPipe[i] = mPipe[i-1];
      mPipe[0] = mkBeat(mBusy, mIdx, mPay);
      if (mBusy) begin
        if (mIdx == NB - 1) mBusy = 0;
        else mIdx++;
      end else if (loadValid) begin
        mBusy = 1; mIdx = 0; mPay = loadWord;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (running) begin
      if (!mBusy) chk("R6", "idle beat", PW'(linkBeat), '0);
      else if (loadValid) chk("R2", "beat under busy request", PW'(linkBeat), PW'(mkBeat(mBusy, mIdx, mPay)));
      else chk("R3", "beat content", PW'(linkBeat), PW'(mkBeat(mBusy, mIdx, mPay)));
      if (mBusy) chk("R4", "last flag", PW'(linkBeat[SW+1]), PW'(mIdx == NB - 1));
      if (mBusy && mIdx == NB - 1)
        chk("R10", "padding bits", PW'(linkBeat[SW-1:PW-(NB-1)*SW]), '0);
      chk("R5", "txIdle", PW'(txIdle), PW'(!mBusy));
      chk("R7", "rxDone", PW'(rxDone), PW'(mDone));
      if (mDone && mDoneCount > 1) chk("R9", "word after count reset", rxWord, mWord);
      else chk("R8", "rxWord", rxWord, mWord);
    end
  end

  always @(posedge clk) begin
    if (cyc > 50000) begin
      nFail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  function automatic logic [PW-1:0] rnd256();
    logic [PW-1:0] v;
    for (int i = 0; i < PW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic sendWord(logic [PW-1:0] w);
    @(negedge clk);
    while (!txIdle) @(negedge clk);
    #1;
    loadValid = 1'b1;
    loadWord  = w;
    @(negedge clk);
    #1;
    loadValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset txIdle", PW'(txIdle), PW'(1'b1));
    chk("R1", "reset linkBeat", PW'(linkBeat), '0);
    chk("R1", "reset rxDone", PW'(rxDone), '0);
    chk("R1", "reset rxWord", rxWord, '0);
    #1 rstN = 1'b1;
    running = 1;
    idle(2);

    // all ones: exercises padding of the final beat
    sendWord('1);
    idle(20);

    // load request while busy must be ignored
    sendWord({32{8'hA5}});
    for (int i = 0; i < 6; i++) begin
      #1; loadValid = 1'b1; loadWord = {32{8'h3C}};
      @(negedge clk);
    end
    #1 loadValid = 1'b0;
    idle(20);

    // single set bits at both ends
    sendWord(PW'(1));
    idle(16);
    sendWord({1'b1, {(PW-1){1'b0}}});
    idle(16);
    sendWord('0);
    idle(16);

    // request held high: payloads follow each other as soon as idle
    for (int i = 0; i < 60; i++) begin
      #1; loadValid = 1'b1; loadWord = rnd256();
      @(negedge clk);
    end
    #1 loadValid = 1'b0;
    idle(20);

    for (int i = 0; i < 4; i++) begin
      sendWord(rnd256());
      idle(3 + i);
    end
    idle(25);

    chk("R9", "completions seen", PW'(mDoneCount >= 10), PW'(1'b1));
    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule